// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block carries out block transfers for one DMA channel. Software first loads a source address, a destination address, a 24-bit unit count and a 16-bit control word. A run request then starts a run that moves one element per unit over a request/acknowledge memory port. The element size is 1, 2, 4, 8 or 32 bytes. After each acknowledged unit, the engine steps both addresses according to their own modes and decrements the count. It keeps the updated address and count values on its status outputs, so progress can be read between units.

A run request gives a run length. A length of zero, or a length larger than what remains, means the whole remaining count. A loaded count of zero stands for 2^24 units. When the count is used up, the engine sets the transfer-end bit in its copy of the control word. If interrupts are enabled, it also raises a level interrupt. A one-cycle done pulse marks the end of every run, whether the run was partial or complete.

Top module: `dma_xfer_engine`

## Requirements
- R1: Control bits [6:4] select the unit size in bytes on `mem_size`: code 0 gives 8, code 1 gives 1, code 2 gives 2, code 3 gives 4, code 4 gives 32, and codes 5, 6 and 7 give 1.
- R2: Control bits [13:12] set the source address mode and bits [15:14] set the destination address mode. Mode 0 keeps the address unchanged. Mode 1 adds the unit size after each unit. Mode 2 subtracts the unit size after each unit.
- R3: Address mode 3 keeps that address fixed and sets `mode_err` when a run starts. `mode_err` stays set until the next `cfg_load`.
- R4: A run starts only if control bits [1:0] equal 2'b01 and `glb_ctrl` equals 3'b001. Otherwise the run request is ignored: no `mem_req`, no `done`, and the status registers do not change.
- R5: Each cycle with `mem_req` and `mem_ack` both high completes one unit. In the next cycle, `cur_src`, `cur_dst` and `cur_cnt` show the stepped addresses and the count minus one. With no acknowledge, they hold their values.
- R6: A run lasts `run_len` units. If `run_len` is zero or larger than the remaining count, the run lasts for the remaining count.
- R7: `done` pulses for exactly one cycle, in the cycle after the last unit of a run is acknowledged. The pulse occurs for partial runs and for full runs.
- R8: When the count reaches zero, control bit 1 (transfer end) is set in `cur_ctrl`. `irq` then goes high and stays high if control bit 2 (interrupt enable) is set, and stays low otherwise.
- R9: A loaded count of zero means 2^24 units. A run of n units from that state leaves the count at 2^24 - n and does not set transfer end.
- R10: `mem_src_dev` reflects control bit 9 and `mem_dst_dev` reflects control bit 8. These are the device flags of the resource field.
- R11: After reset, `mem_req`, `done`, `irq` and `mode_err` are low and all status registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_ctrl | input | 3 | Global operation control; must be 3'b001 for a run to start |
| cfg_load | input | 1 | Loads the channel registers below and aborts any run |
| cfg_src | input | ADDR_W | Source address to load |
| cfg_dst | input | ADDR_W | Destination address to load |
| cfg_cnt | input | CNT_W | Unit count to load (0 = 2^24) |
| cfg_ctrl | input | 16 | Control word to load |
| run_req | input | 1 | Starts a run when the engine is idle |
| run_len | input | CNT_W | Units in this run (0 = all remaining) |
| mem_req | output | 1 | Unit transfer request |
| mem_rd_addr | output | ADDR_W | Read address of the current unit |
| mem_wr_addr | output | ADDR_W | Write address of the current unit |
| mem_size | output | 6 | Unit size in bytes |
| mem_src_dev | output | 1 | Source is a device |
| mem_dst_dev | output | 1 | Destination is a device |
| mem_ack | input | 1 | Unit completed |
| cur_src | output | ADDR_W | Current source address |
| cur_dst | output | ADDR_W | Current destination address |
| cur_cnt | output | CNT_W | Remaining count |
| cur_ctrl | output | 16 | Control word, including transfer end |
| done | output | 1 | One-cycle pulse at the end of a run |
| irq | output | 1 | Channel interrupt |
| mode_err | output | 1 | Illegal address mode seen |

## Verification
The bench walks all eight size codes. A table with the irregular 32-byte code or the upper codes off by one would show up as a wrong `mem_size` and a wrong final destination address. It splits one transfer into a partial run and a completing run. This catches an engine that sets transfer end on run completion rather than on count exhaustion, or that fails to pulse `done` after a partial run. It loads a count of zero with a short run length. A design that treats zero as empty would do no work, and one that truncates the 25-bit limit would stop early or set transfer end. It also drives illegal modes, disabled channels, and a global control value whose upper bits are set. A decoder that checks only the low bit would start transfers when it should not.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_BAD   = 2'd3
  } addr_mode_e;

  // Control word bit positions
  localparam int CTL_DE       = 0;
  localparam int CTL_TE       = 1;
  localparam int CTL_IE       = 2;
  localparam int CTL_SZ_LSB   = 4;
  localparam int CTL_DST_DEV  = 8;
  localparam int CTL_SRC_DEV  = 9;
  localparam int CTL_SRC_MODE = 12;
  localparam int CTL_DST_MODE = 14;
  localparam int CTL_W        = 16;
  localparam int SIZE_W       = 6;
  localparam logic [2:0] GLB_RUN = 3'b001;
endpackage

// File: rtl/dma_size_decode.sv
module dma_size_decode #(
  parameter int SIZE_W = 6
) (
  input  logic [2:0]        code,
  output logic [SIZE_W-1:0] bytes
);
  always_comb begin
    case (code)
      3'd0:    bytes = SIZE_W'(8);
      3'd2:    bytes = SIZE_W'(2);
      3'd3:    bytes = SIZE_W'(4);
      3'd4:    bytes = SIZE_W'(32);
      default: bytes = SIZE_W'(1);
    endcase
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  addr_mode_e        mode,
  input  logic [SIZE_W-1:0] unit,
  output logic [ADDR_W-1:0] next,
  output logic              illegal
);
  logic [ADDR_W-1:0] unit_ext;
  assign unit_ext = ADDR_W'(unit);

  always_comb begin
    illegal = 1'b0;
    case (mode)
      AM_INC:  next = addr + unit_ext;
      AM_DEC:  next = addr - unit_ext;
      AM_BAD:  begin next = addr; illegal = 1'b1; end
      default: next = addr;
    endcase
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        glb_ctrl,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic [15:0]       cfg_ctrl,
  input  logic              run_req,
  input  logic [CNT_W-1:0]  run_len,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [5:0]        mem_size,
  output logic              mem_src_dev,
  output logic              mem_dst_dev,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [15:0]       cur_ctrl,
  output logic              done,
  output logic              irq,
  output logic              mode_err
);
  localparam int LEFT_W = CNT_W + 1;
  localparam logic [LEFT_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
  localparam int NPTR = 2; // index 0 = source, 1 = destination

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic [LEFT_W-1:0] left_q;
  logic              busy_q, done_q, irq_q, err_q;

  logic [SIZE_W-1:0] unit_bytes;
  logic [ADDR_W-1:0] ptr_cur [NPTR];
  logic [ADDR_W-1:0] ptr_nxt [NPTR];
  logic [1:0]        ptr_mode [NPTR];
  logic [NPTR-1:0]   ptr_ill;

  dma_size_decode #(.SIZE_W(SIZE_W)) u_size (
    .code  (ctrl_q[CTL_SZ_LSB +: 3]),
    .bytes (unit_bytes)
  );

  assign ptr_cur[0]  = src_q;
  assign ptr_cur[1]  = dst_q;
  assign ptr_mode[0] = ctrl_q[CTL_SRC_MODE +: 2];
  assign ptr_mode[1] = ctrl_q[CTL_DST_MODE +: 2];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
      .addr    (ptr_cur[g]),
      .mode    (addr_mode_e'(ptr_mode[g])),
      .unit    (unit_bytes),
      .next    (ptr_nxt[g]),
      .illegal (ptr_ill[g])
    );
  end

  // Run admission and length clamp
  logic              chan_ok;
  logic [LEFT_W-1:0] avail, len_ext, first_left;
  assign chan_ok    = (ctrl_q[CTL_TE:CTL_DE] == 2'b01) && (glb_ctrl == GLB_RUN);
  assign avail      = (cnt_q == '0) ? FULL_CNT : {1'b0, cnt_q};
  assign len_ext    = {1'b0, run_len};
  assign first_left = (run_len == '0 || len_ext > avail) ? avail : len_ext;

  logic last_of_count, last_of_run;
  assign last_of_count = (cnt_q == CNT_W'(1));
  assign last_of_run   = (left_q == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_load) begin
        src_q  <= cfg_src;
        dst_q  <= cfg_dst;
        cnt_q  <= cfg_cnt;
        ctrl_q <= cfg_ctrl;
        left_q <= '0;
        busy_q <= 1'b0;
        irq_q  <= 1'b0;
        err_q  <= 1'b0;
      end else if (!busy_q) begin
        if (run_req && chan_ok) begin
          busy_q <= 1'b1;
          left_q <= first_left;
          err_q  <= err_q | (|ptr_ill);
        end
      end else if (mem_ack) begin
        src_q  <= ptr_nxt[0];
        dst_q  <= ptr_nxt[1];
        cnt_q  <= cnt_q - CNT_W'(1);
        left_q <= left_q - LEFT_W'(1);
        if (last_of_count) begin
          ctrl_q[CTL_TE] <= 1'b1;
          irq_q          <= ctrl_q[CTL_IE];
          busy_q         <= 1'b0;
          done_q         <= 1'b1;
        end else if (last_of_run) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign mem_req     = busy_q;
  assign mem_rd_addr = src_q;
  assign mem_wr_addr = dst_q;
  assign mem_size    = unit_bytes;
  assign mem_src_dev = ctrl_q[CTL_SRC_DEV];
  assign mem_dst_dev = ctrl_q[CTL_DST_DEV];
  assign cur_src     = src_q;
  assign cur_dst     = dst_q;
  assign cur_cnt     = cnt_q;
  assign cur_ctrl    = ctrl_q;
  assign done        = done_q;
  assign irq         = irq_q;
  assign mode_err    = err_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] cur_src,
  input logic [ADDR_W-1:0] cur_dst,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [15:0]       cur_ctrl,
  input logic              done,
  input logic              irq,
  input logic              mode_err
);
  // R4: requests only while the channel control is enabled and not ended
  a_r4_req_enabled: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (cur_ctrl[1:0] == 2'b01));

  // R5: each acknowledged unit lowers the count by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !cfg_load) |=> (cur_cnt == CNT_W'($past(cur_cnt) - CNT_W'(1))));

  // R5: no acknowledge, no change of progress
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!(mem_req && mem_ack) && !cfg_load) |=>
      ($stable(cur_src) && $stable(cur_dst) && $stable(cur_cnt)));

  // R3: error flag is sticky until reload
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode_err && !cfg_load) |=> mode_err);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: interrupt only with transfer end and interrupt enable
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cur_ctrl[1] && cur_ctrl[2]));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .mem_req(mem_req), .mem_ack(mem_ack),
  .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt), .cur_ctrl(cur_ctrl),
  .done(done), .irq(irq), .mode_err(mode_err)
);

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  glb_ctrl = 3'b001;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [23:0] cfg_cnt = '0;
  logic [15:0] cfg_ctrl = '0;
  logic        run_req = 1'b0;
  logic [23:0] run_len = '0;
  logic        mem_req, mem_src_dev, mem_dst_dev, done, irq, mode_err;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rd_addr, mem_wr_addr, cur_src, cur_dst;
  logic [5:0]  mem_size;
  logic [23:0] cur_cnt;
  logic [15:0] cur_ctrl;

  always #4 clk = ~clk;

  dma_xfer_engine uut (
    .clk(clk), .rst(rst), .glb_ctrl(glb_ctrl), .cfg_load(cfg_load),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_ctrl(cfg_ctrl),
    .run_req(run_req), .run_len(run_len), .mem_req(mem_req),
    .mem_rd_addr(mem_rd_addr), .mem_wr_addr(mem_wr_addr), .mem_size(mem_size),
    .mem_src_dev(mem_src_dev), .mem_dst_dev(mem_dst_dev), .mem_ack(mem_ack),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt), .cur_ctrl(cur_ctrl),
    .done(done), .irq(irq), .mode_err(mode_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Memory responder: acknowledges every requested unit and logs it
  logic [31:0] lg_src [64];
  logic [31:0] lg_dst [64];
  logic [5:0]  lg_sz  [64];
  logic        lg_sd  [64];
  logic        lg_dd  [64];
  int n_units = 0;
  int n_done  = 0;

  always @(negedge clk) begin
    if (done) n_done++;
    if (mem_req && n_units < 64) begin
      lg_src[n_units] = mem_rd_addr;
      lg_dst[n_units] = mem_wr_addr;
      lg_sz[n_units]  = mem_size;
      lg_sd[n_units]  = mem_src_dev;
      lg_dd[n_units]  = mem_dst_dev;
      n_units++;
      mem_ack <= 1'b1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int size_of(int code);
    case (code)
      0: return 8;
      2: return 2;
      3: return 4;
      4: return 32;
      default: return 1;
    endcase
  endfunction

  task automatic load(logic [31:0] s, logic [31:0] d, logic [23:0] c, logic [15:0] k);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_cnt = c; cfg_ctrl = k; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Pulse run_req and wait for done (or a short timeout)
  task automatic run(logic [23:0] len, int max_cyc);
    int d0;
    d0 = n_done;
    run_len = len; run_req = 1'b1;
    @(negedge clk);
    run_req = 1'b0;
    for (int i = 0; i < max_cyc && n_done == d0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_units(string tag, int base, int n, logic [31:0] s0, int ss,
                              logic [31:0] d0, int ds, int sz);
    chk({tag, " unit count"}, 32'(n_units - base), 32'(n));
    for (int k = 0; k < n; k++) begin
      chk({tag, " src addr"}, lg_src[base+k], s0 + 32'(k*ss));
      chk({tag, " dst addr"}, lg_dst[base+k], d0 + 32'(k*ds));
      chk({tag, " size"}, 32'(lg_sz[base+k]), 32'(sz));
    end
  endtask

  task automatic t_reset();
    chk("R11 mem_req", 32'(mem_req), 0);
    chk("R11 done", 32'(done), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 mode_err", 32'(mode_err), 0);
    chk("R11 cnt", 32'(cur_cnt), 0);
    chk("R11 ctrl", 32'(cur_ctrl), 0);
  endtask

  // Both incrementing, 4-byte units, full run, interrupt enabled
  task automatic t_inc_full();
    int b, d0;
    load(32'h100, 32'h2000, 24'd3, 16'h5035);
    b = n_units; d0 = n_done;
    run(24'd0, 40);
    expect_units("R2 R6 inc", b, 3, 32'h100, 4, 32'h2000, 4, 4);
    chk("R5 src writeback", cur_src, 32'h10C);
    chk("R5 dst writeback", cur_dst, 32'h200C);
    chk("R5 count", 32'(cur_cnt), 0);
    chk("R8 te set", 32'(cur_ctrl[1]), 1);
    chk("R8 irq", 32'(irq), 1);
    chk("R7 one done", 32'(n_done - d0), 1);
  endtask

  // 32-byte units, source decrement, dest fixed, split into two runs
  task automatic t_partial();
    int b, d0;
    load(32'h1000, 32'h0, 24'd5, 16'h2045);
    b = n_units; d0 = n_done;
    run(24'd2, 40);
    expect_units("R2 R6 partial", b, 2, 32'h1000, -32, 32'h0, 0, 32);
    chk("R7 partial done", 32'(n_done - d0), 1);
    chk("R8 no te after partial", 32'(cur_ctrl[1]), 0);
    chk("R8 no irq after partial", 32'(irq), 0);
    chk("R5 count after partial", 32'(cur_cnt), 3);
    chk("R5 src after partial", cur_src, 32'hFC0);
    b = n_units;
    run(24'd0, 40);
    expect_units("R6 remainder", b, 3, 32'hFC0, -32, 32'h0, 0, 32);
    chk("R2 src final", cur_src, 32'hF60);
    chk("R8 te final", 32'(cur_ctrl[1]), 1);
    chk("R8 irq final", 32'(irq), 1);
    chk("R7 two dones", 32'(n_done - d0), 2);
  endtask

  task automatic t_sizes();
    for (int code = 0; code < 8; code++) begin
      int b;
      load(32'h40, 32'h800, 24'd1, 16'(16'h4001 | (code << 4)));
      b = n_units;
      run(24'd0, 20);
      chk("R1 size units", 32'(n_units - b), 1);
      chk("R1 size code", 32'(lg_sz[b]), 32'(size_of(code)));
      chk("R1 dst step", cur_dst, 32'h800 + 32'(size_of(code)));
    end
  endtask

  task automatic t_disabled();
    int b, d0;
    b = n_units; d0 = n_done;
    load(32'h500, 32'h600, 24'd4, 16'h5037);   // transfer end already set
    run(24'd0, 8);
    load(32'h500, 32'h600, 24'd4, 16'h5034);   // enable clear
    run(24'd0, 8);
    load(32'h500, 32'h600, 24'd4, 16'h5035);
    glb_ctrl = 3'b011;                          // global upper bit set
    run(24'd0, 8);
    glb_ctrl = 3'b001;
    chk("R4 no units", 32'(n_units - b), 0);
    chk("R4 no done", 32'(n_done - d0), 0);
    chk("R4 src kept", cur_src, 32'h500);
    chk("R4 cnt kept", 32'(cur_cnt), 4);
  endtask

  task automatic t_bad_mode();
    int b;
    load(32'h300, 32'h700, 24'd2, 16'hF031);
    chk("R3 err clear on load", 32'(mode_err), 0);
    b = n_units;
    run(24'd0, 20);
    expect_units("R3 fixed", b, 2, 32'h300, 0, 32'h700, 0, 4);
    chk("R3 err set", 32'(mode_err), 1);
    chk("R8 te without ie", 32'(cur_ctrl[1]), 1);
    chk("R8 irq masked", 32'(irq), 0);
    load(32'h300, 32'h700, 24'd2, 16'h5031);
    chk("R3 err cleared by reload", 32'(mode_err), 0);
  endtask

  task automatic t_zero_count();
    int b;
    load(32'h0, 32'h100, 24'd0, 16'h5015);
    b = n_units;
    run(24'd3, 20);
    expect_units("R9 zero count", b, 3, 32'h0, 1, 32'h100, 1, 1);
    chk("R9 count wraps", 32'(cur_cnt), 32'hFFFFFD);
    chk("R9 no te", 32'(cur_ctrl[1]), 0);
  endtask

  task automatic t_limit();
    int b;
    load(32'h10, 32'h20, 24'd2, 16'h5025);
    b = n_units;
    run(24'd9, 30);
    chk("R6 clamp units", 32'(n_units - b), 2);
    chk("R6 clamp te", 32'(cur_ctrl[1]), 1);
  endtask

  task automatic t_device();
    int b;
    load(32'h10, 32'h20, 24'd1, 16'h0311);
    b = n_units;
    run(24'd0, 20);
    chk("R10 src dev", 32'(lg_sd[b]), 1);
    chk("R10 dst dev", 32'(lg_dd[b]), 1);
    load(32'h10, 32'h20, 24'd1, 16'h0211);
    b = n_units;
    run(24'd0, 20);
    chk("R10 src dev only", 32'(lg_sd[b]), 1);
    chk("R10 dst mem", 32'(lg_dd[b]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_inc_full();
    t_partial();
    t_sizes();
    t_disabled();
    t_bad_mode();
    t_zero_count();
    t_limit();
    t_device();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule